// File: doc/BRIEF.md
# Fixed-Rate Dual-Clock Elastic Buffer

This block carries a stream of 32-bit words from a fast write clock to a slower read clock. The two clocks are unrelated in phase but run at a 3:2 frequency ratio. The writer offers a word in two of every three write cycles, and the reader takes one word on every read cycle. The average rates are therefore equal, so the buffer needs neither full nor empty flags. Words sit in a 16-entry dual-port memory. Each side keeps a plain binary pointer in its own clock domain, and the pointers are never exchanged.

The only signal that crosses between the domains is a one-bit level. The write side raises it once eight words have been stored since reset, and a two-flop synchronizer brings it into the read domain. When the read side first sees this level, it starts reading at address 0. It then reads one word per cycle, without a stall, until its reset. The eight-word head start keeps the read pointer about half a buffer behind the write pointer.

Top module: `fixed_rate_ebuf`

## Requirements
- R1: Every word accepted on `wr_data_i` while `wr_en_i` is high comes out on `rd_data_o` with `rd_valid_o` high, in write order, with none lost, repeated or reordered.
- R2: While `rrst_ni` is low and after its release, `rd_valid_o` stays low until at least 8 words have been written since the write-side reset.
- R3: Once `rd_valid_o` goes high, it stays high on every read clock cycle until the read-side reset. One new word is delivered per read cycle.
- R4: Both pointers are 4-bit binary counters that wrap modulo 16. Order is kept across thousands of wraps.
- R5: The start indication is a single level. It rises after the 8th write, stays high until the write reset and passes through two flops in the read domain. Reading begins at address 0, so the first word delivered is the first word written after reset.
- R6: Each active-low asynchronous reset clears only its own side: the pointer and the primed or running state. After both resets, the output sequence starts again with the first word written after the reset.
- R7: A write cycle with `wr_en_i` low stores nothing and does not advance the write pointer. Data presented in such a cycle never appears at the output.
- R8: Read data is registered: a word appears one read clock after its address is presented, and `rd_valid_o` is delayed to match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write clock (the faster clock) |
| wrst_ni | input | 1 | Write-side asynchronous reset, active low |
| wr_en_i | input | 1 | Write enable, high for two of every three write cycles |
| wr_data_i | input | 32 | Word to store |
| rclk_i | input | 1 | Read clock, two thirds of the write clock frequency |
| rrst_ni | input | 1 | Read-side asynchronous reset, active low |
| rd_data_o | output | 32 | Word read from the buffer |
| rd_valid_o | output | 1 | High when `rd_data_o` carries a word; stays high once reading starts |

## Verification
The bench writes an incrementing sequence and drives marker data in every idle write cycle. A design that writes on idle cycles, or whose read pointer skips or jumps (for example 0, 17, 2, 19), then shows a mismatch against the scoreboard. Two enable phasings (1-1-0 and 1-0-1) and an odd phase offset between the clocks run the pointers through more than a hundred wraps each. At the first valid word the bench checks that at least eight words were written and that the word is the first one written. This catches a start that comes too early or does not begin at address 0. A full reset between the phasings checks that the valid output drops and that the sequence restarts cleanly. It also checks that valid never falls while reading is running.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;
  localparam int unsigned EBUF_DATA_W = 32;
  localparam int unsigned EBUF_DEPTH  = 16;
  localparam int unsigned EBUF_FILL   = 8;
endpackage

// File: rtl/ebuf_dpram.sv
// One write port on wclk, one registered read port on rclk.
module ebuf_dpram #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rclk_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i) begin
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/ebuf_wr_ctrl.sv
// Write pointer and fill counter; primed rises after FILL writes, then holds.
module ebuf_wr_ctrl #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned FILL  = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(FILL + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  output logic [AW-1:0] wptr_o,
  output logic          primed_o
);
  logic [CW-1:0] fill_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_o     <= '0;
      fill_cnt_q <= '0;
      primed_o   <= 1'b0;
    end else if (wr_en_i) begin
      wptr_o <= wptr_o + 1'b1;
      if (!primed_o) begin
        fill_cnt_q <= fill_cnt_q + 1'b1;
        if (fill_cnt_q == CW'(FILL - 1)) primed_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ebuf_sync.sv
module ebuf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/ebuf_rd_ctrl.sv
// Starts once on the synchronized start level, then advances every cycle.
module ebuf_rd_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic [AW-1:0] rptr_o,
  output logic          run_o,
  output logic          valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_o  <= '0;
      run_o   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      run_o   <= run_o | start_i;
      valid_o <= run_o;  // matches the registered memory read
      if (run_o) rptr_o <= rptr_o + 1'b1;
    end
  end
endmodule

// File: rtl/fixed_rate_ebuf.sv
module fixed_rate_ebuf #(
  parameter int unsigned DATA_W    = ebuf_pkg::EBUF_DATA_W,
  parameter int unsigned DEPTH     = ebuf_pkg::EBUF_DEPTH,
  parameter int unsigned FILL      = ebuf_pkg::EBUF_FILL,
  parameter int unsigned SYNC_STGS = 2,
  localparam int unsigned AW       = $clog2(DEPTH)
) (
  input  logic              wclk_i,
  input  logic              wrst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rclk_i,
  input  logic              rrst_ni,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  logic [AW-1:0] wptr, rptr;
  logic          primed, primed_s, run;

  ebuf_wr_ctrl #(.DEPTH(DEPTH), .FILL(FILL)) i_wr_ctrl (
    .clk_i   (wclk_i),
    .rst_ni  (wrst_ni),
    .wr_en_i (wr_en_i),
    .wptr_o  (wptr),
    .primed_o(primed)
  );

  ebuf_sync #(.STAGES(SYNC_STGS)) i_sync (
    .clk_i (rclk_i),
    .rst_ni(rrst_ni),
    .d_i   (primed),
    .q_o   (primed_s)
  );

  ebuf_rd_ctrl #(.DEPTH(DEPTH)) i_rd_ctrl (
    .clk_i  (rclk_i),
    .rst_ni (rrst_ni),
    .start_i(primed_s),
    .rptr_o (rptr),
    .run_o  (run),
    .valid_o(rd_valid_o)
  );

  ebuf_dpram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_mem (
    .wclk_i (wclk_i),
    .we_i   (wr_en_i),
    .waddr_i(wptr),
    .wdata_i(wr_data_i),
    .rclk_i (rclk_i),
    .re_i   (run),
    .raddr_i(rptr),
    .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/fixed_rate_ebuf_chk.sv
module fixed_rate_ebuf_chk #(
  parameter int unsigned AW = 4
) (
  input logic          wclk_i,
  input logic          wrst_ni,
  input logic          wr_en_i,
  input logic          rclk_i,
  input logic          rrst_ni,
  input logic          rd_valid_o,
  input logic [AW-1:0] wptr,
  input logic [AW-1:0] rptr,
  input logic          primed,
  input logic          primed_s,
  input logic          run
);
  // R7 / R4: write pointer moves by one per enabled cycle only
  a_r4_wptr_step: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    wr_en_i |=> wptr == $past(wptr) + 1'b1);
  a_r7_wptr_hold: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    !wr_en_i |=> $stable(wptr));
  // R5: primed level holds once raised
  a_r5_primed_holds: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    primed |=> primed);
  // R5: reading begins at address 0
  a_r5_start_at_zero: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    $rose(run) |-> rptr == '0);
  // R4: read pointer steps by one every running cycle
  a_r4_rptr_step: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    run |=> rptr == $past(rptr) + 1'b1);
  // R2: no valid data before the start level has crossed
  a_r2_no_early_valid: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    !primed_s |-> !rd_valid_o);
  // R3: valid never drops while running
  a_r3_valid_holds: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    rd_valid_o |=> rd_valid_o);
  // R8: valid follows run by one read cycle
  a_r8_valid_lag: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    run |=> rd_valid_o);
endmodule

bind fixed_rate_ebuf fixed_rate_ebuf_chk #(.AW(AW)) i_chk (
  .wclk_i    (wclk_i),
  .wrst_ni   (wrst_ni),
  .wr_en_i   (wr_en_i),
  .rclk_i    (rclk_i),
  .rrst_ni   (rrst_ni),
  .rd_valid_o(rd_valid_o),
  .wptr      (wptr),
  .rptr      (rptr),
  .primed    (primed),
  .primed_s  (primed_s),
  .run       (run)
);

// File: tb/test_fixed_rate_ebuf.sv
`timescale 1ns/1ps
module test_fixed_rate_ebuf;
  localparam int FILL = 8;

  logic        wclk = 1'b0, rclk = 1'b0;
  logic        wrst_n = 1'b0, rrst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_valid;

  int n_cmp = 0, n_err = 0;
  int n_written = 0;
  bit active = 0, seen_valid = 0, done = 0;
  logic [31:0] first_word;
  logic [31:0] exp_q[$];

  always #2.5 wclk = ~wclk;          // 200 MHz write clock
  initial begin
    #1.7;                            // arbitrary phase offset
    forever #3.75 rclk = ~rclk;      // 3:2 ratio
  end

  fixed_rate_ebuf i_fixed_rate_ebuf (
    .wclk_i(wclk), .wrst_ni(wrst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rclk_i(rclk), .rrst_ni(rrst_n), .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops expected words as valid data appears
  always @(negedge rclk) begin
    if (!rrst_n) begin
      if (active) check(rd_valid == 1'b0, "R2 reset valid", {31'b0, rd_valid}, 32'h0);
    end else if (active) begin
      if (rd_valid) begin
        if (!seen_valid) begin
          check(n_written >= FILL, "R2 fill before start", n_written, FILL);
          check(rd_data == first_word, "R5 first word", rd_data, first_word);
          seen_valid = 1;
        end
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 output with nothing written", rd_data, 32'h0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check(rd_data == e, "R1/R4/R7 order", rd_data, e);
        end
      end else if (seen_valid) begin
        check(1'b0, "R3 valid dropped", 32'h0, 32'h1);
      end
    end
  end

  task automatic do_reset();
    @(negedge wclk);
    wr_en  = 1'b0;
    wrst_n = 1'b0;
    rrst_n = 1'b0;
    repeat (4) @(negedge rclk);
    exp_q.delete();
    n_written  = 0;
    seen_valid = 0;
    @(negedge rclk) rrst_n = 1'b1;
    @(negedge wclk) wrst_n = 1'b1;
  endtask

  // Driver: 2-of-3 cadence, idle cycles carry marker data
  task automatic run_phase(input bit [2:0] pat, input int cycles, input logic [31:0] base);
    first_word = base;
    for (int c = 0; c < cycles; c++) begin
      @(negedge wclk);
      if (pat[c % 3]) begin
        wr_en   = 1'b1;
        wr_data = base + 32'(n_written);
        exp_q.push_back(wr_data);
        n_written++;
      end else begin
        wr_en   = 1'b0;
        wr_data = 32'hDEAD_0000 ^ 32'(c);
      end
    end
  endtask

  initial begin
    #20;
    active = 1;
    check(rd_valid == 1'b0, "R2 valid low in reset", {31'b0, rd_valid}, 32'h0);
    do_reset();
    check(rd_valid == 1'b0, "R2 valid low after release", {31'b0, rd_valid}, 32'h0);
    run_phase(3'b011, 4500, 32'h1000_0000);
    check(seen_valid == 1'b1, "R3 reading started", {31'b0, seen_valid}, 32'h1);
    check(exp_q.size() < 16, "R4 lag within depth", exp_q.size(), 16);
    do_reset();
    check(rd_valid == 1'b0, "R6 valid cleared by reset", {31'b0, rd_valid}, 32'h0);
    run_phase(3'b101, 4500, 32'h2000_0000);
    check(seen_valid == 1'b1, "R6 restart after reset", {31'b0, seen_valid}, 32'h1);
    check(n_cmp > 5000, "R4 many wraps compared", n_cmp, 5000);
    active = 0;
    @(negedge wclk) wr_en = 1'b0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_cmp++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end
endmodule